// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes queued in a small first-in first-out store into asynchronous serial frames on one output line. A character goes in through a simple write strobe. While the block is enabled it pulls the oldest stored character and shifts it out as a framed word:

- a low start bit;
- five to eight data bits, least significant bit first;
- an optional even or odd parity bit;
- one or two high stop bits.

Bit timing comes from a reference tick generated outside the block. One bit lasts sixteen ticks, or eight in the fast timing option.

Frames follow one another with no idle gap until the store is empty. The line-control inputs are captured when each frame begins, so software can change them at any time without damaging a frame already in progress. A busy output reports that work is still outstanding: either characters are stored, or a frame is still on the wire. Busy falls only after the final stop bit has fully elapsed, and it keeps its meaning when the enable is cleared.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever busy is low, the serial line `tx` is high and `busy` is low.
- R2: A frame starts with one low bit, followed by `cfg_len`+5 data bits (`cfg_len` 0..3 gives 5..8 bits) taken from the low bits of the character, least significant bit first.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_odd`=0 the count of ones in the data bits plus the parity bit is even; with `cfg_par_odd`=1 it is odd. Only the active data bits are counted.
- R4: The data (and parity bit, if any) are followed by one high stop bit, or two when `cfg_stop2` is 1.
- R5: Every bit lasts 16 cycles in which `tick` is high, or 8 when `cfg_fast` is 1. The line changes only on such ticks, or when a new frame is loaded.
- R6: The store holds 16 characters and returns them in write order. A write while it is full is dropped and leaves the stored entries intact.
- R7: While enabled and characters remain stored, the next frame's start bit begins in the cycle right after the previous frame's last stop bit ends.
- R8: `busy` rises in the cycle after an accepted write. It stays high through the last stop bit, and falls in the first cycle after that bit once the store is empty.
- R9: While `en` is low no new frame starts. A frame already in progress completes, and `busy` stays high as long as characters remain stored.
- R10: The line-control inputs are captured when a frame is loaded; changing them mid-frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Allows new frames to start |
| tick | input | 1 | Baud reference tick, one cycle wide |
| wr_valid | input | 1 | Write strobe for the character store |
| wr_data | input | 8 | Character to store |
| cfg_len | input | 2 | Data length code: bit count is value+5 |
| cfg_par_en | input | 1 | Adds a parity bit |
| cfg_par_odd | input | 1 | Selects odd parity when 1, even when 0 |
| cfg_stop2 | input | 1 | Selects two stop bits |
| cfg_fast | input | 1 | Selects 8 ticks per bit instead of 16 |
| tx | output | 1 | Serial output, idles high |
| busy | output | 1 | Stored data or frame in flight |

## Verification
A corrupted bit counter or tick counter shows up as a data bit sampled in the wrong place, or as a frame whose length is off by a whole bit period. Either fault is visible within one frame at mid-bit sampling and at the exact cycle `busy` falls. A wrong store pointer or count shows up as characters out of order, lost or repeated during a sixteen-deep back-to-back burst, or as `busy` dropping while characters remain. Captured line control that leaks through mid-frame changes the length or parity of the frame already on the wire, which shows before its stop bits end.

// File: rtl/uart_frame_tx_pkg.sv
package uart_frame_tx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
        logic       fast;
    } line_cfg_t;

    // Mask selecting the active data bits for a length code (0..3 -> 5..8 bits)
    function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] len);
        return {CHAR_W{1'b1}} >> (2'd3 - len);
    endfunction

endpackage

// File: rtl/uart_frame_tx_fifo.sv
module uart_frame_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             push_data,
    input  logic                         pop,
    output logic [WIDTH-1:0]             head,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wptr;
        logic [AW-1:0]               rptr;
        logic [CW-1:0]               cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic push_ok, pop_ok;

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.cnt != CW'(DEPTH));
        pop_ok  = pop && (st_q.cnt != '0);
        if (push_ok) begin
            st_d.mem[st_q.wptr] = push_data;
            st_d.wptr = (st_q.wptr == LAST) ? '0 : st_q.wptr + 1'b1;
        end
        if (pop_ok) begin
            st_d.rptr = (st_q.rptr == LAST) ? '0 : st_q.rptr + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rptr];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign count = st_q.cnt;

endmodule

// File: rtl/uart_frame_tx_shifter.sv
module uart_frame_tx_shifter
    import uart_frame_tx_pkg::*;
#(
    parameter int SLOW_TICKS = 16,
    parameter int FAST_TICKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    input  line_cfg_t         load_cfg,
    output logic              tx,
    output logic              active,
    output logic              frame_done
);
    localparam int TW = $clog2(SLOW_TICKS);
    localparam logic [TW-1:0] SLOW_LAST = TW'(SLOW_TICKS-1);
    localparam logic [TW-1:0] FAST_LAST = TW'(FAST_TICKS-1);

    typedef struct packed {
        tx_state_e         state;
        logic [1:0]        len;
        logic              par_en;
        logic              stop2;
        logic              fast;
        logic [CHAR_W-1:0] shreg;
        logic              par;
        logic [TW-1:0]     tcnt;
        logic [2:0]        bcnt;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic         bit_end;
    logic [CHAR_W-1:0] masked;

    always_comb begin
        st_d    = st_q;
        bit_end = (st_q.state != ST_IDLE) && tick &&
                  (st_q.tcnt == (st_q.fast ? FAST_LAST : SLOW_LAST));
        frame_done = bit_end && (st_q.state == ST_STOP) &&
                     (!st_q.stop2 || st_q.bcnt == 3'd1);
        masked  = load_data & len_mask(load_cfg.len);

        if (st_q.state != ST_IDLE && tick) begin
            st_d.tcnt = bit_end ? '0 : st_q.tcnt + 1'b1;
        end

        if (bit_end) begin
            unique case (st_q.state)
                ST_START: begin
                    st_d.state = ST_DATA;
                    st_d.bcnt  = '0;
                end
                ST_DATA: begin
                    st_d.shreg = st_q.shreg >> 1;
                    if (st_q.bcnt == ({1'b0, st_q.len} + 3'd4)) begin
                        st_d.state = st_q.par_en ? ST_PAR : ST_STOP;
                        st_d.bcnt  = '0;
                    end else begin
                        st_d.bcnt  = st_q.bcnt + 3'd1;
                    end
                end
                ST_PAR: begin
                    st_d.state = ST_STOP;
                    st_d.bcnt  = '0;
                end
                ST_STOP: begin
                    if (st_q.stop2 && st_q.bcnt == 3'd0) st_d.bcnt  = 3'd1;
                    else                                 st_d.state = ST_IDLE;
                end
                default: st_d.state = ST_IDLE;
            endcase
        end

        if (load) begin
            st_d.state  = ST_START;
            st_d.len    = load_cfg.len;
            st_d.par_en = load_cfg.par_en;
            st_d.stop2  = load_cfg.stop2;
            st_d.fast   = load_cfg.fast;
            st_d.shreg  = masked;
            st_d.par    = (^masked) ^ load_cfg.par_odd;
            st_d.tcnt   = '0;
            st_d.bcnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: ST_IDLE, default: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q.state)
            ST_START: tx = 1'b0;
            ST_DATA:  tx = st_q.shreg[0];
            ST_PAR:   tx = st_q.par;
            default:  tx = 1'b1;
        endcase
    end

    assign active = (st_q.state != ST_IDLE);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_frame_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int SLOW_TICKS = 16,
    parameter int FAST_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_stop2,
    input  logic       cfg_fast,
    output logic       tx,
    output logic       busy
);
    localparam int CW = $clog2(FIFO_DEPTH+1);

    logic [CHAR_W-1:0] fifo_head;
    logic              fifo_empty;
    logic              fifo_full;
    logic [CW-1:0]     fifo_count;
    logic              fifo_pop;
    logic              frame_active;
    logic              frame_done;
    line_cfg_t         cfg_now;

    assign cfg_now = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd,
                       stop2: cfg_stop2, fast: cfg_fast};

    // A new frame loads from idle, or in the last tick of the previous frame
    assign fifo_pop = en && !fifo_empty && (!frame_active || frame_done);

    uart_frame_tx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (CHAR_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_valid),
        .push_data (wr_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .count     (fifo_count)
    );

    uart_frame_tx_shifter #(
        .SLOW_TICKS (SLOW_TICKS),
        .FAST_TICKS (FAST_TICKS)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (fifo_pop),
        .load_data  (fifo_head),
        .load_cfg   (cfg_now),
        .tx         (tx),
        .active     (frame_active),
        .frame_done (frame_done)
    );

    assign busy = !fifo_empty || frame_active;

endmodule

// File: rtl/uart_frame_tx_checker.sv
module uart_frame_tx_checker #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       en,
    input logic                       tick,
    input logic                       wr_valid,
    input logic                       tx,
    input logic                       busy,
    input logic                       fifo_pop,
    input logic                       frame_active,
    input logic                       fifo_full,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count
);
    localparam int CW = $clog2(DEPTH+1);

    assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);

    assert_busy_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !busy) |=> busy);

    assert_no_start_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !frame_active) |=> !frame_active);

    assert_full_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !fifo_pop) |=> (fifo_count == CW'(DEPTH)));

    assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    assert_line_moves_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !fifo_pop) |=> $stable(tx));

endmodule

bind uart_frame_tx uart_frame_tx_checker #(.DEPTH(FIFO_DEPTH)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .tick         (tick),
    .wr_valid     (wr_valid),
    .tx           (tx),
    .busy         (busy),
    .fifo_pop     (fifo_pop),
    .frame_active (frame_active),
    .fifo_full    (fifo_full),
    .fifo_count   (fifo_count)
);

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_fast = 1'b0;
    logic       tx;
    logic       busy;

    int tests_run = 0;
    int tests_failed = 0;
    int tick_div = 1;
    int tick_phase = 0;

    always #5 clk = ~clk;

    uart_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .cfg_fast(cfg_fast),
        .tx(tx), .busy(busy)
    );

    always @(negedge clk) begin
        if (tick_phase >= tick_div - 1) begin
            tick = 1'b1;
            tick_phase = 0;
        end else begin
            tick = 1'b0;
            tick_phase++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic set_cfg(input int len, input int pe, input int po,
                           input int s2, input int fast);
        cfg_len     = 2'(len);
        cfg_par_en  = 1'(pe);
        cfg_par_odd = 1'(po);
        cfg_stop2   = 1'(s2);
        cfg_fast    = 1'(fast);
    endtask

    // nextmode: 0 idle and not busy, 1 next start bit follows, 2 idle but busy
    task automatic capture(input logic [7:0] d, input int len, input int pe,
                           input int po, input int s2, input int fast,
                           input int nextmode, input string req);
        int p, nbits, stop_err;
        logic [7:0] rx, expd;
        logic pbit, expp;
        p = (fast ? 8 : 16) * tick_div;
        nbits = len + 5;
        expd = d & (8'hFF >> (3 - len));
        rx = '0;
        pbit = 1'b0;
        stop_err = 0;
        while (tx !== 1'b0) @(negedge clk);
        wait_neg(p / 2);
        check(tx === 1'b0, "R2", "start bit", int'(tx), 0);
        for (int i = 0; i < nbits; i++) begin
            wait_neg(p);
            rx[i] = tx;
        end
        if (pe != 0) begin
            wait_neg(p);
            pbit = tx;
        end
        for (int s = 0; s < 1 + s2; s++) begin
            wait_neg(p);
            if (tx !== 1'b1) stop_err++;
        end
        check(rx === expd, req, "data bits", int'(rx), int'(expd));
        if (pe != 0) begin
            expp = (^expd) ^ po[0];
            check(pbit === expp, "R3", "parity bit", int'(pbit), int'(expp));
        end
        check(stop_err == 0, "R4", "stop bits low count", stop_err, 0);
        if (tick_div == 1) begin
            wait_neg(p / 2 - 1);
            check(tx === 1'b1 && busy === 1'b1, "R5", "last stop bit still held",
                  int'({tx, busy}), 3);
            wait_neg(1);
            case (nextmode)
                0: check(busy === 1'b0 && tx === 1'b1, "R8", "release after stop",
                         int'({tx, busy}), 2);
                1: check(tx === 1'b0, "R7", "back-to-back start", int'(tx), 0);
                default: check(tx === 1'b1 && busy === 1'b1, "R9", "held while disabled",
                               int'({tx, busy}), 3);
            endcase
        end else begin
            wait_neg(p / 2 + tick_div + 1);
            if (nextmode == 0)
                check(busy === 1'b0 && tx === 1'b1, "R8", "release after stop",
                      int'({tx, busy}), 2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        int idx;
        wait_neg(4);
        check(tx === 1'b1 && busy === 1'b0, "R1", "line during reset", int'({tx, busy}), 2);
        rst_n = 1'b1;
        wait_neg(3);
        check(tx === 1'b1 && busy === 1'b0, "R1", "line after reset", int'({tx, busy}), 2);

        // Busy rises one cycle after an accepted write (R8)
        en = 1'b1;
        set_cfg(3, 0, 0, 0, 1);
        push(8'h81);
        check(busy === 1'b1, "R8", "busy after write", int'(busy), 1);
        capture(8'h81, 3, 0, 0, 0, 1, 0, "R2");

        // Sweep every frame shape (R2 R3 R4 R5)
        idx = 0;
        for (int f = 0; f < 2; f++)
            for (int l = 0; l < 4; l++)
                for (int pm = 0; pm < 3; pm++)
                    for (int s = 0; s < 2; s++) begin
                        logic [7:0] d;
                        d = 8'((idx * 73 + 29) & 255);
                        idx++;
                        set_cfg(l, pm != 0, pm == 2, s, f);
                        push(d);
                        capture(d, l, pm != 0, pm == 2, s, f, 0, "R2");
                    end

        // Slower tick: bit length follows ticks, not cycles (R5)
        tick_div = 3;
        for (int k = 0; k < 4; k++) begin
            set_cfg(k, k[0], k[1], k[0], k[1]);
            push(8'(8'h5A + k * 9));
            capture(8'(8'h5A + k * 9), k, k[0], k[1], k[0], k[1], 0, "R5");
        end
        tick_div = 1;

        // Mid-frame line-control change has no effect (R10)
        set_cfg(3, 0, 0, 0, 0);
        push(8'hA5);
        fork
            capture(8'hA5, 3, 0, 0, 0, 0, 0, "R10");
            begin
                while (tx !== 1'b0) @(negedge clk);
                wait_neg(20);
                set_cfg(0, 1, 1, 1, 1);
            end
        join

        // Disable during a frame: it finishes, next waits (R9)
        set_cfg(3, 1, 0, 0, 1);
        push(8'h3C);
        push(8'h5A);
        fork
            capture(8'h3C, 3, 1, 0, 0, 1, 2, "R9");
            begin
                while (tx !== 1'b0) @(negedge clk);
                wait_neg(5);
                en = 1'b0;
            end
        join
        wait_neg(200);
        check(tx === 1'b1 && busy === 1'b1, "R9", "no start while disabled",
              int'({tx, busy}), 3);
        en = 1'b1;
        capture(8'h5A, 3, 1, 0, 0, 1, 0, "R9");

        // Fill past capacity, then drain back to back (R6 R7)
        en = 1'b0;
        set_cfg(3, 0, 0, 0, 1);
        for (int k = 0; k < 18; k++) push(8'((k * 17) & 255));
        wait_neg(2);
        check(tx === 1'b1 && busy === 1'b1, "R9", "stored while disabled",
              int'({tx, busy}), 3);
        en = 1'b1;
        for (int k = 0; k < 16; k++)
            capture(8'((k * 17) & 255), 3, 0, 0, 0, 1, (k == 15) ? 0 : 1, "R6");
        wait_neg(50);
        check(tx === 1'b1 && busy === 1'b0, "R6", "no dropped write sent",
              int'({tx, busy}), 2);

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule